// File: doc/BRIEF.md
# Text-Mode Display Address Generator

This block generates the 16-bit address that a legacy CRT controller presents to its frame buffer decoder while it scans text or graphics memory. An internal memory address counter is loaded with a start address when a frame begins. It returns to a saved row-start value at the beginning of every scan line, and that saved value moves forward by a programmable row offset whenever the row scan count wraps. Between these loads the counter advances once every 1, 2 or 4 character clock enables, depending on two mode bits.

On its way to the output the counter value is first reorganised for byte, word or doubleword addressing. Then row scan bits 0 and 1 may be placed in address bits 13 and 14, each under its own keep bit. The block also produces the clock enable for the vertical timing counter. This enable follows every horizontal retrace, or every second one when the vertical-divide bit is set. Both outputs are registered.

Top module: `crtc_addr_gen`

## Requirements
- R1: After reset, fb_addr is 0, vclk_en is 0, the internal counter is 0 and the advance interval is one character clock until the first load.
- R2: The advance interval, latched at each load, is 1 enable for (cfg_ul4=0, cfg_cnt2=0), 2 for (0,1), 4 for (1,0) and 2 for (1,1). The counter adds 1 on the Nth char_en after a load and on every Nth one after that.
- R3: A change of cfg_ul4 or cfg_cnt2 has no effect on the advance rate until the next frame_start or line_start. Every load restarts the interval count from zero.
- R4: frame_start loads start_addr into both the counter and the saved row start. It takes priority over line_start and char_en in the same cycle.
- R5: line_start without row_wrap reloads the counter from the saved row start. line_start with row_wrap first adds row_offset (modulo 2^16) to the saved row start and loads the counter with the sum.
- R6: cfg_addr_mode 0 (byte) and 3 (treated as byte) pass the counter through unchanged.
- R7: cfg_addr_mode 1 (word) gives {cnt[14:0], b}, where b is cnt[15] when cfg_word_hi=1 and cnt[13] when cfg_word_hi=0.
- R8: cfg_addr_mode 2 (doubleword) gives {cnt[13:0], cnt[13], cnt[12]}.
- R9: When cfg_keep14=0, fb_addr[14] is row_scan_lo[1] in place of the reorganised bit 14. When cfg_keep14=1, the reorganised bit passes through.
- R10: When cfg_keep13=0, fb_addr[13] is row_scan_lo[0]. When cfg_keep13=1, the reorganised bit passes through. This substitution is independent of R9.
- R11: With cfg_vdiv2=0, vclk_en is 1 in the cycle after each cycle with hretrace=1, and 0 otherwise.
- R12: With cfg_vdiv2=1, vclk_en follows only every second hretrace pulse. The phase is cleared by reset, so the first pulse after reset produces no enable.
- R13: fb_addr reflects the counter, mode bits and row_scan_lo of the previous clock cycle (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_en | input | 1 | Character clock enable |
| frame_start | input | 1 | Load start address (new frame) |
| line_start | input | 1 | Reload counter from saved row start (new scan line) |
| row_wrap | input | 1 | With line_start: row scan count wrapped, add row offset |
| start_addr | input | 16 | Frame start address |
| row_offset | input | 16 | Amount added to the row start on row wrap |
| row_scan_lo | input | 2 | Low two bits of the row scan count |
| hretrace | input | 1 | One-cycle horizontal retrace pulse |
| cfg_ul4 | input | 1 | Interval select bit (underline-location type) |
| cfg_cnt2 | input | 1 | Count-by-two bit |
| cfg_addr_mode | input | 2 | 0 byte, 1 word, 2 doubleword, 3 byte |
| cfg_word_hi | input | 1 | Word mode: bit 15 (1) or bit 13 (0) into address bit 0 |
| cfg_keep13 | input | 1 | 0 = put row scan bit 0 into address bit 13 |
| cfg_keep14 | input | 1 | 0 = put row scan bit 1 into address bit 14 |
| cfg_vdiv2 | input | 1 | Vertical enable on every second retrace |
| fb_addr | output | 16 | Frame buffer address (registered) |
| vclk_en | output | 1 | Vertical timing counter clock enable (registered) |

## Verification
The bench changes the interval bits between loads. A design that applied the new rate at once, instead of at the next load, would drift from the model within a few enables. Loads arrive while the prescaler is part-way through a count, and a frame_start and line_start can fall in the same cycle. Leftover prescaler state would make an early advance, and a wrong priority would load the saved row start instead of the new frame address. Each addressing mode runs with every keep-bit combination, so a swapped fill bit or a substitution applied before the reorganisation shows up as a wrong bit 0, 1, 13 or 14. The bench also checks that the first retrace after reset gives no enable in divided mode, which catches a toggle that starts in the wrong phase.

// File: rtl/crtc_addr_pkg.sv
package crtc_addr_pkg;

  typedef enum logic [1:0] {
    AM_BYTE     = 2'd0,
    AM_WORD     = 2'd1,
    AM_DWORD    = 2'd2,
    AM_BYTE_ALT = 2'd3
  } addr_mode_e;

  // interval encoded as (enables per advance) - 1
  typedef logic [1:0] ivl_code_t;

  function automatic ivl_code_t ivl_decode(input logic ul4, input logic cnt2);
    ivl_code_t r;
    if (cnt2)     r = 2'd1;   // every 2, regardless of ul4
    else if (ul4) r = 2'd3;   // every 4
    else          r = 2'd0;   // every 1
    return r;
  endfunction

endpackage

// File: rtl/crtc_rate_presc.sv
module crtc_rate_presc
  import crtc_addr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic char_en,
  input  logic cfg_ul4,
  input  logic cfg_cnt2,
  output logic advance
);

  ivl_code_t pre_cnt;
  ivl_code_t ivl_last;

  assign advance = char_en && !load && (pre_cnt == ivl_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt  <= '0;
      ivl_last <= '0;
    end else if (load) begin
      pre_cnt  <= '0;
      ivl_last <= ivl_decode(cfg_ul4, cfg_cnt2);
    end else if (char_en) begin
      if (pre_cnt == ivl_last) pre_cnt <= '0;
      else                     pre_cnt <= pre_cnt + 2'd1;
    end
  end

endmodule

// File: rtl/crtc_ma_counter.sv
module crtc_ma_counter #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              row_wrap,
  input  logic              advance,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] row_offset,
  output logic [ADDR_W-1:0] ma_cnt
);

  logic [ADDR_W-1:0] row_base;
  logic [ADDR_W-1:0] next_base;

  assign next_base = row_wrap ? (row_base + row_offset) : row_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      ma_cnt   <= '0;
      row_base <= '0;
    end else if (frame_start) begin
      ma_cnt   <= start_addr;
      row_base <= start_addr;
    end else if (line_start) begin
      ma_cnt   <= next_base;
      row_base <= next_base;
    end else if (advance) begin
      ma_cnt   <= ma_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/crtc_addr_remap.sv
module crtc_addr_remap
  import crtc_addr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SUB_LO = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ma_cnt,
  input  logic [1:0]        mode,
  input  logic              word_hi,
  input  logic [1:0]        row_scan_lo,
  input  logic [1:0]        sub_keep,
  output logic [ADDR_W-1:0] fb_addr
);

  localparam int WFILL_HI = ADDR_W - 1;
  localparam int WFILL_LO = ADDR_W - 3;
  localparam int DFILL_1  = ADDR_W - 3;
  localparam int DFILL_0  = ADDR_W - 4;

  logic [ADDR_W-1:0] reorg;
  logic [ADDR_W-1:0] subst;

  always_comb begin
    unique case (addr_mode_e'(mode))
      AM_WORD:  reorg = {ma_cnt[ADDR_W-2:0],
                         word_hi ? ma_cnt[WFILL_HI] : ma_cnt[WFILL_LO]};
      AM_DWORD: reorg = {ma_cnt[ADDR_W-3:0], ma_cnt[DFILL_1], ma_cnt[DFILL_0]};
      default:  reorg = ma_cnt;
    endcase
  end

  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_bit
    if (gi >= SUB_LO && gi < SUB_LO + 2) begin : g_sub
      assign subst[gi] = sub_keep[gi-SUB_LO] ? reorg[gi] : row_scan_lo[gi-SUB_LO];
    end else begin : g_pass
      assign subst[gi] = reorg[gi];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fb_addr <= '0;
    else     fb_addr <= subst;
  end

endmodule

// File: rtl/crtc_vclk_div.sv
module crtc_vclk_div (
  input  logic clk,
  input  logic rst,
  input  logic hretrace,
  input  logic div2,
  output logic vclk_en
);

  logic phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 1'b0;
      vclk_en <= 1'b0;
    end else begin
      vclk_en <= hretrace && (!div2 || phase);
      if (hretrace) phase <= !phase;
    end
  end

endmodule

// File: rtl/crtc_addr_gen.sv
module crtc_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int SUB_LO = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_en,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              row_wrap,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] row_offset,
  input  logic [1:0]        row_scan_lo,
  input  logic              hretrace,
  input  logic              cfg_ul4,
  input  logic              cfg_cnt2,
  input  logic [1:0]        cfg_addr_mode,
  input  logic              cfg_word_hi,
  input  logic              cfg_keep13,
  input  logic              cfg_keep14,
  input  logic              cfg_vdiv2,
  output logic [ADDR_W-1:0] fb_addr,
  output logic              vclk_en
);

  logic              load;
  logic              advance;
  logic [ADDR_W-1:0] ma_cnt;

  assign load = frame_start || line_start;

  crtc_rate_presc u_presc (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .char_en  (char_en),
    .cfg_ul4  (cfg_ul4),
    .cfg_cnt2 (cfg_cnt2),
    .advance  (advance)
  );

  crtc_ma_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .line_start  (line_start),
    .row_wrap    (row_wrap),
    .advance     (advance),
    .start_addr  (start_addr),
    .row_offset  (row_offset),
    .ma_cnt      (ma_cnt)
  );

  crtc_addr_remap #(.ADDR_W(ADDR_W), .SUB_LO(SUB_LO)) u_remap (
    .clk         (clk),
    .rst         (rst),
    .ma_cnt      (ma_cnt),
    .mode        (cfg_addr_mode),
    .word_hi     (cfg_word_hi),
    .row_scan_lo (row_scan_lo),
    .sub_keep    ({cfg_keep14, cfg_keep13}),
    .fb_addr     (fb_addr)
  );

  crtc_vclk_div u_vdiv (
    .clk      (clk),
    .rst      (rst),
    .hretrace (hretrace),
    .div2     (cfg_vdiv2),
    .vclk_en  (vclk_en)
  );

endmodule

// File: rtl/crtc_addr_gen_chk.sv
module crtc_addr_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int SUB_LO = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start,
  input logic [ADDR_W-1:0] start_addr,
  input logic [1:0]        row_scan_lo,
  input logic              hretrace,
  input logic [1:0]        cfg_addr_mode,
  input logic              cfg_keep13,
  input logic              cfg_keep14,
  input logic              cfg_vdiv2,
  input logic [ADDR_W-1:0] ma_cnt,
  input logic [ADDR_W-1:0] fb_addr,
  input logic              vclk_en
);

  // R4
  frame_load_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (ma_cnt == $past(start_addr)));

  // R6
  byte_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr_mode == 2'd0 && cfg_keep13 && cfg_keep14) |=> (fb_addr == $past(ma_cnt)));

  // R9
  sub14_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_keep14 |=> (fb_addr[SUB_LO+1] == $past(row_scan_lo[1])));

  // R10
  sub13_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_keep13 |=> (fb_addr[SUB_LO] == $past(row_scan_lo[0])));

  // R11
  vclk_direct_chk: assert property (@(posedge clk) disable iff (rst)
    (hretrace && !cfg_vdiv2) |=> vclk_en);

  // R11
  vclk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hretrace |=> !vclk_en);

endmodule

bind crtc_addr_gen crtc_addr_gen_chk #(.ADDR_W(ADDR_W), .SUB_LO(SUB_LO)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .frame_start   (frame_start),
  .start_addr    (start_addr),
  .row_scan_lo   (row_scan_lo),
  .hretrace      (hretrace),
  .cfg_addr_mode (cfg_addr_mode),
  .cfg_keep13    (cfg_keep13),
  .cfg_keep14    (cfg_keep14),
  .cfg_vdiv2     (cfg_vdiv2),
  .ma_cnt        (ma_cnt),
  .fb_addr       (fb_addr),
  .vclk_en       (vclk_en)
);

// File: tb/crtc_addr_gen_tb.sv
`timescale 1ns/1ps
module crtc_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        char_en = 0, frame_start = 0, line_start = 0, row_wrap = 0;
  logic [15:0] start_addr = 0, row_offset = 0;
  logic [1:0]  row_scan_lo = 0;
  logic        hretrace = 0;
  logic        cfg_ul4 = 0, cfg_cnt2 = 0;
  logic [1:0]  cfg_addr_mode = 0;
  logic        cfg_word_hi = 0, cfg_keep13 = 1, cfg_keep14 = 1, cfg_vdiv2 = 0;
  logic [15:0] fb_addr;
  logic        vclk_en;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  bit    cmp_on = 0;
  bit    done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  crtc_addr_gen u_dut (
    .clk(clk), .rst(rst), .char_en(char_en), .frame_start(frame_start),
    .line_start(line_start), .row_wrap(row_wrap), .start_addr(start_addr),
    .row_offset(row_offset), .row_scan_lo(row_scan_lo), .hretrace(hretrace),
    .cfg_ul4(cfg_ul4), .cfg_cnt2(cfg_cnt2), .cfg_addr_mode(cfg_addr_mode),
    .cfg_word_hi(cfg_word_hi), .cfg_keep13(cfg_keep13), .cfg_keep14(cfg_keep14),
    .cfg_vdiv2(cfg_vdiv2), .fb_addr(fb_addr), .vclk_en(vclk_en)
  );

  // behavioural reference model
  int m_cnt, m_base, m_pre, m_ivl, m_fb, m_v;
  bit m_tog;

  function automatic int ivl_of(bit u, bit c);
    if (c) return 2;
    if (u) return 4;
    return 1;
  endfunction

  function automatic int expect_addr(int cnt);
    int a;
    case (cfg_addr_mode)
      2'd1: a = ((cnt << 1) & 32'hFFFF) | (cfg_word_hi ? ((cnt >> 15) & 1) : ((cnt >> 13) & 1));
      2'd2: a = ((cnt << 2) & 32'hFFFF) | ((cnt >> 12) & 3);
      default: a = cnt;
    endcase
    if (!cfg_keep13) a = (a & ~(1 << 13)) | (int'(row_scan_lo[0]) << 13);
    if (!cfg_keep14) a = (a & ~(1 << 14)) | (int'(row_scan_lo[1]) << 14);
    return a;
  endfunction

  always @(posedge clk) begin
    int nfb, nv;
    cyc++;
    if (rst) begin
      m_cnt = 0; m_base = 0; m_pre = 0; m_ivl = 1; m_fb = 0; m_v = 0; m_tog = 0;
    end else begin
      nfb = expect_addr(m_cnt);
      nv  = (hretrace && (!cfg_vdiv2 || m_tog)) ? 1 : 0;
      if (hretrace) m_tog = !m_tog;
      if (frame_start) begin
        m_cnt = start_addr; m_base = start_addr; m_pre = 0; m_ivl = ivl_of(cfg_ul4, cfg_cnt2);
      end else if (line_start) begin
        if (row_wrap) m_base = (m_base + row_offset) & 32'hFFFF;
        m_cnt = m_base; m_pre = 0; m_ivl = ivl_of(cfg_ul4, cfg_cnt2);
      end else if (char_en) begin
        m_pre++;
        if (m_pre == m_ivl) begin
          m_pre = 0;
          m_cnt = (m_cnt + 1) & 32'hFFFF;
        end
      end
      m_fb = nfb; m_v = nv;
    end
  end

  task automatic check(string t, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check({tag, " R13 fb_addr"}, int'(fb_addr), m_fb);
      check({tag, " vclk_en"}, int'(vclk_en), m_v);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; char_en = 0; frame_start = 0; line_start = 0; hretrace = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic run_rand(int n, int fs_mod, int ls_mod, int hr_mod);
    repeat (n) begin
      @(negedge clk);
      char_en     = ($urandom % 4) != 0;
      frame_start = ($urandom % fs_mod) == 0;
      line_start  = ($urandom % ls_mod) == 0;
      row_wrap    = $urandom % 2;
      start_addr  = 16'($urandom);
      row_offset  = 16'($urandom % 200);
      row_scan_lo = 2'($urandom);
      hretrace    = ($urandom % hr_mod) == 0;
    end
    @(negedge clk);
    char_en = 0; frame_start = 0; line_start = 0; hretrace = 0;
  endtask

  task automatic frame_load(logic [15:0] a);
    @(negedge clk);
    frame_start = 1; start_addr = a; char_en = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic count_enables(int n);
    repeat (n) begin
      @(negedge clk);
      char_en = 1;
    end
    @(negedge clk);
    char_en = 0;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 reset fb_addr", int'(fb_addr), 0);
    check("R1 reset vclk_en", int'(vclk_en), 0);
    cmp_on = 1;
    // R1: interval one before any load
    tag = "R1 interval";
    count_enables(3);
    @(negedge clk);
    check("R1 three advances", int'(fb_addr), 3);

    // R2: all four interval combinations, directed then random
    for (int k = 0; k < 4; k++) begin
      cfg_ul4 = k[1]; cfg_cnt2 = k[0];
      tag = $sformatf("R2 ul4=%0d cnt2=%0d", k[1], k[0]);
      frame_load(16'h0100);
      count_enables(7);
      @(negedge clk);
      check({tag, " after 8 enables"}, int'(fb_addr), 16'h0100 + 8 / ivl_of(k[1], k[0]));
      run_rand(300, 64, 20, 7);
    end

    // R3: change interval without a load, then load
    tag = "R3 late change";
    cfg_ul4 = 1; cfg_cnt2 = 0;
    frame_load(16'h0200);
    count_enables(1);
    cfg_ul4 = 0; cfg_cnt2 = 0;
    count_enables(3);
    @(negedge clk);
    check("R3 old interval kept", int'(fb_addr), 16'h0201);
    run_rand(300, 40, 6, 9);

    // R4/R5: frame vs line priority, row offset on wrap
    tag = "R4 frame priority";
    @(negedge clk);
    frame_start = 1; line_start = 1; row_wrap = 1; start_addr = 16'h1234; row_offset = 16'h0050;
    @(negedge clk);
    frame_start = 0; line_start = 0;
    @(negedge clk);
    check("R4 frame wins", int'(fb_addr), 16'h1234);
    tag = "R5 row wrap";
    @(negedge clk);
    line_start = 1; row_wrap = 1; row_offset = 16'h0050;
    @(negedge clk);
    line_start = 0; row_wrap = 0;
    @(negedge clk);
    check("R5 base plus offset", int'(fb_addr), 16'h1284);
    run_rand(400, 50, 5, 9);

    // R6 R7 R8 R9 R10: every address mode with every substitution pair
    for (int md = 0; md < 4; md++) begin
      for (int sb = 0; sb < 4; sb++) begin
        cfg_addr_mode = 2'(md); cfg_keep13 = sb[0]; cfg_keep14 = sb[1];
        for (int wh = 0; wh < 2; wh++) begin
          cfg_word_hi = wh[0];
          case (md)
            1: tag = "R7 word";
            2: tag = "R8 dword";
            default: tag = "R6 byte";
          endcase
          if (sb != 3) tag = {tag, (sb[0] ? "" : " R10"), (sb[1] ? "" : " R9")};
          frame_load(16'($urandom));
          run_rand(120, 80, 16, 11);
        end
      end
    end
    cfg_addr_mode = 0; cfg_keep13 = 1; cfg_keep14 = 1;

    // R11: direct vertical enable
    tag = "R11 direct";
    cfg_vdiv2 = 0;
    run_rand(300, 64, 16, 3);

    // R12: divided, phase from reset
    cmp_on = 0;
    cfg_vdiv2 = 1;
    do_reset();
    cmp_on = 1;
    tag = "R12 divided";
    @(negedge clk); hretrace = 1;
    @(negedge clk); hretrace = 0;
    check("R12 first retrace suppressed", int'(vclk_en), 0);
    @(negedge clk); hretrace = 1;
    @(negedge clk); hretrace = 0;
    check("R12 second retrace passes", int'(vclk_en), 1);
    run_rand(400, 64, 16, 3);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule